// File: doc/BRIEF.md
# Per-Core Event Capture and Interrupt Unit

Each processor core owns one copy of this unit. It gathers seven single-cycle hardware events into sticky flags. Three events are produced inside the unit: a 32-bit reload timer, a pin-edge detector on a 64-bit pin bus, and an execution-address breakpoint comparator. The other four arrive as strobes from neighbouring logic: transfer rollover, transfer block wrap, mailbox read and mailbox write.

Software can route any one event to a level interrupt by writing a 3-bit mode code. The pipeline can also issue requests on a poll port. A request either reads and clears a flag in the same cycle, or waits for an event. A wait can run until the event arrives, or until a free-running cycle counter reaches a given limit.

The edge detector samples the selected pin through registers. It ignores comparisons for two cycles after a new pin or edge kind is written, so that a selection change cannot produce a false edge. While an edge interrupt is being handled, further edge interrupts are held off until the handler signals its return.

Top module: `evt_irq_unit`

## Requirements
- R1: `irq_o` is a level that is high while the flag selected by the registered mode is set. The mode codes are: 0 none, 1 timer, 2 pin edge, 3 transfer rollover, 4 transfer block wrap, 5 mailbox read, 6 mailbox write, 7 execution-address match.
- R2: A pulse on `irq_ack_i` with a nonzero mode clears the selected flag, so `irq_o` is low in the next cycle unless a new event for that flag arrives in the same cycle.
- R3: A nonzero timer period P raises the timer event once every P cycles. The first flag is set P+1 clock edges after the period write. A period of 0 stops the timer, and no timer event follows.
- R4: The edge configuration word holds the pin index in bits [5:0] and the edge kind in bits [7:6]. The kinds are 00 none, 01 rising, 10 falling and 11 either. A detected edge sets the edge flag two clock edges after the pin changes.
- R5: For two cycles after a configuration write, the edge detector reports no edge. A newly selected pin that differs from the old pin therefore causes no event.
- R6: The breakpoint event fires when `exec_valid_i` is high and `exec_addr_i` equals the programmed address. This holds both at or below 0x7FC (core-local space) and above it (shared space). Before the first address write, the breakpoint never fires.
- R7: A request with `req_take_i`=1 and `req_timed_i`=0 returns the flag in the same cycle on `resp_flag_o`, with `resp_valid_o`=1, and clears the flag at the next edge.
- R8: When an event and any clear (poll, wait completion or acknowledge) hit the same flag in the same cycle, the flag ends up set.
- R9: A request with `req_timed_i`=1 waits for its event. If `cnt_o` equals `req_limit_i` before the event, the unit answers with `resp_timeout_o`=1 and `resp_flag_o`=0. If the event comes first, it answers with `resp_flag_o`=1 and `resp_timeout_o`=0.
- R10: A request with neither option keeps `busy_o` high indefinitely until the event flag is set. It then answers with `resp_flag_o`=1 and clears that flag.
- R11: After an acknowledge in mode 2, `irq_o` stays low until `irq_ret_i` pulses, even if new edges are captured. After the return, a pending edge flag raises `irq_o`.
- R12: Request event indices are 0 timer, 1 edge, 2 rollover, 3 block wrap, 4 mailbox read, 5 mailbox write and 6 breakpoint. Each strobe sets only its own flag, and index 7 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tmr_period_we_i | input | 1 | Load timer period |
| tmr_period_i | input | 32 | Timer period, 0 stops the timer |
| edge_cfg_we_i | input | 1 | Load edge configuration |
| edge_cfg_i | input | 8 | Edge kind [7:6], pin index [5:0] |
| pins_i | input | 64 | Pin bus |
| bkpt_we_i | input | 1 | Load breakpoint address |
| bkpt_addr_i | input | 20 | Breakpoint address |
| exec_valid_i | input | 1 | Execution address valid |
| exec_addr_i | input | 20 | Executing address |
| xfer_roll_i | input | 1 | Transfer rollover strobe |
| xfer_wrap_i | input | 1 | Transfer block wrap strobe |
| mbox_rd_i | input | 1 | Mailbox read alert strobe |
| mbox_wr_i | input | 1 | Mailbox write alert strobe |
| irq_mode_we_i | input | 1 | Load interrupt mode |
| irq_mode_i | input | 3 | Interrupt mode code |
| irq_o | output | 1 | Interrupt request level |
| irq_ack_i | input | 1 | Acknowledge, clears selected flag |
| irq_ret_i | input | 1 | Handler return, ends edge hold-off |
| req_valid_i | input | 1 | Poll/wait request |
| req_evt_i | input | 3 | Event index |
| req_take_i | input | 1 | Poll and clear option |
| req_timed_i | input | 1 | Timed wait option |
| req_limit_i | input | 32 | Timeout counter value |
| resp_valid_o | output | 1 | Response valid |
| resp_flag_o | output | 1 | Event flag result |
| resp_timeout_o | output | 1 | Wait ended on timeout |
| busy_o | output | 1 | Wait in progress |
| cnt_o | output | 32 | Free-running cycle counter |

## Verification
The assertions check several properties on every cycle:
- an event that collides with a clear still leaves its flag set;
- an acknowledge drops the request line;
- an edge-mode acknowledge keeps the line low;
- a poll clears only when no event arrives alongside it;
- a completed wait frees the port;
- the edge detector stays silent right after a configuration write;
- the timer never fires in back-to-back cycles for periods above one.

Other behaviour can only be shown by the bench's scenarios. This covers the exact timer cadence and the disable case, and the rising, falling and either-edge encodings. It also covers the breakpoint match on both sides of the local/shared boundary, the cycle on which a timed wait expires, and the release of edge interrupts after the handler returns.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int NUM_EVT = 7;
  localparam int IDX_W   = 3;

  typedef enum logic [2:0] {
    EV_TMR  = 3'd0,
    EV_EDGE = 3'd1,
    EV_ROLL = 3'd2,
    EV_WRAP = 3'd3,
    EV_MRD  = 3'd4,
    EV_MWR  = 3'd5,
    EV_EXEC = 3'd6
  } evt_idx_e;

  typedef enum logic [2:0] {
    IM_OFF  = 3'd0,
    IM_TMR  = 3'd1,
    IM_EDGE = 3'd2,
    IM_ROLL = 3'd3,
    IM_WRAP = 3'd4,
    IM_MRD  = 3'd5,
    IM_MWR  = 3'd6,
    IM_EXEC = 3'd7
  } irq_mode_e;

  typedef enum logic [1:0] {
    EK_NONE = 2'b00,
    EK_RISE = 2'b01,
    EK_FALL = 2'b10,
    EK_ANY  = 2'b11
  } edge_kind_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } wait_st_e;
endpackage

// File: rtl/evt_timer.sv
module evt_timer #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             period_we_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             evt_o
);
  logic [CNT_W-1:0] period_q;
  logic [CNT_W-1:0] tick_q;
  logic             wrap;

  assign wrap  = (period_q != '0) && (tick_q == period_q - CNT_W'(1));
  assign evt_o = wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q <= '0;
      tick_q   <= '0;
    end else if (period_we_i) begin
      period_q <= period_i;
      tick_q   <= '0;
    end else if (period_q != '0) begin
      tick_q <= wrap ? '0 : tick_q + CNT_W'(1);
    end
  end

  // R3: reload spacing, no back-to-back events for periods above one
  p_tmr_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o && period_q > CNT_W'(1) && !period_we_i) |=> !evt_o);

  // R3: a stopped timer holds its count at zero
  p_tmr_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_q == '0) |-> (tick_q == '0));
endmodule

// File: rtl/evt_edge_det.sv
module evt_edge_det #(
  parameter int PIN_N = 64,
  localparam int SEL_W = $clog2(PIN_N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [SEL_W+1:0] cfg_i,
  input  logic [PIN_N-1:0] pins_i,
  output logic             evt_o
);
  import evt_pkg::*;

  logic [SEL_W-1:0] sel_q;
  edge_kind_e       kind_q;
  logic             s1_q, s2_q;
  logic [1:0]       warm_q;
  logic             rise, fall;

  assign rise  = s1_q & ~s2_q;
  assign fall  = ~s1_q & s2_q;
  assign evt_o = (warm_q == 2'd2) && ((kind_q[0] && rise) || (kind_q[1] && fall));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      kind_q <= EK_NONE;
      warm_q <= 2'd0;
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
    end else begin
      s1_q <= pins_i[sel_q];
      s2_q <= s1_q;
      if (cfg_we_i) begin
        sel_q  <= cfg_i[SEL_W-1:0];
        kind_q <= edge_kind_e'(cfg_i[SEL_W+1:SEL_W]);
        warm_q <= 2'd0;  // both samples must come from the new pin
      end else if (warm_q != 2'd2) begin
        warm_q <= warm_q + 2'd1;
      end
    end
  end

  // R5: silent for two cycles after a selection change
  p_cfg_quiet1_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> !evt_o);
  p_cfg_quiet2_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> ##1 !evt_o);
endmodule

// File: rtl/evt_bkpt.sv
module evt_bkpt #(
  parameter int ADDR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              exec_valid_i,
  input  logic [ADDR_W-1:0] exec_addr_i,
  output logic              evt_o
);
  logic [ADDR_W-1:0] addr_q;
  logic              armed_q;

  // full-width compare: local and shared spaces match alike
  assign evt_o = armed_q && exec_valid_i && (exec_addr_i == addr_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      armed_q <= 1'b0;
    end else if (addr_we_i) begin
      addr_q  <= addr_i;
      armed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/evt_capture.sv
module evt_capture #(
  parameter int CNT_W = 32
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [evt_pkg::NUM_EVT-1:0]  evt_i,
  input  logic                         mode_we_i,
  input  logic [2:0]                   mode_i,
  input  logic                         irq_ack_i,
  input  logic                         irq_ret_i,
  output logic                         irq_o,
  input  logic                         req_valid_i,
  input  logic [evt_pkg::IDX_W-1:0]    req_evt_i,
  input  logic                         req_take_i,
  input  logic                         req_timed_i,
  input  logic [CNT_W-1:0]             req_limit_i,
  output logic                         resp_valid_o,
  output logic                         resp_flag_o,
  output logic                         resp_timeout_o,
  output logic                         busy_o,
  output logic [CNT_W-1:0]             cnt_o
);
  import evt_pkg::*;
  localparam int PAD_N = 2 ** IDX_W;

  logic [NUM_EVT-1:0] flag_q;
  logic [PAD_N-1:0]   flag_pad, evt_pad, clr;
  irq_mode_e          mode_q;
  logic [IDX_W-1:0]   sel_idx;
  logic               edge_hold_q;
  wait_st_e           st_q;
  logic [IDX_W-1:0]   w_evt_q;
  logic               w_timed_q;
  logic [CNT_W-1:0]   w_lim_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               poll_now, wait_go, wait_hit, wait_to, ack_now;

  assign flag_pad = {{(PAD_N-NUM_EVT){1'b0}}, flag_q};
  assign evt_pad  = {{(PAD_N-NUM_EVT){1'b0}}, evt_i};
  assign sel_idx  = IDX_W'(mode_q) - IDX_W'(1);

  assign irq_o = (mode_q != IM_OFF) && flag_pad[sel_idx]
               && !(mode_q == IM_EDGE && edge_hold_q);
  assign ack_now = irq_ack_i && (mode_q != IM_OFF);

  assign poll_now = req_valid_i && (st_q == ST_IDLE) && req_take_i && !req_timed_i;
  assign wait_go  = req_valid_i && (st_q == ST_IDLE) && !(req_take_i && !req_timed_i);
  assign wait_hit = (st_q == ST_WAIT) && flag_pad[w_evt_q];
  assign wait_to  = (st_q == ST_WAIT) && !wait_hit && w_timed_q && (cnt_q == w_lim_q);

  assign resp_valid_o   = poll_now || wait_hit || wait_to;
  assign resp_flag_o    = poll_now ? flag_pad[req_evt_i] : wait_hit;
  assign resp_timeout_o = wait_to;
  assign busy_o         = (st_q == ST_WAIT);
  assign cnt_o          = cnt_q;

  always_comb begin
    clr = '0;
    if (poll_now) clr[req_evt_i] = 1'b1;
    if (wait_hit) clr[w_evt_q]   = 1'b1;
    if (ack_now)  clr[sel_idx]   = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q      <= '0;
      mode_q      <= IM_OFF;
      edge_hold_q <= 1'b0;
      st_q        <= ST_IDLE;
      w_evt_q     <= '0;
      w_timed_q   <= 1'b0;
      w_lim_q     <= '0;
      cnt_q       <= '0;
    end else begin
      cnt_q  <= cnt_q + CNT_W'(1);
      // new events override same-cycle clears
      flag_q <= (flag_q & ~clr[NUM_EVT-1:0]) | evt_i;
      if (mode_we_i) mode_q <= irq_mode_e'(mode_i);
      if (irq_ret_i)
        edge_hold_q <= 1'b0;
      else if (irq_ack_i && mode_q == IM_EDGE)
        edge_hold_q <= 1'b1;
      if (wait_go) begin
        st_q      <= ST_WAIT;
        w_evt_q   <= req_evt_i;
        w_timed_q <= req_timed_i;
        w_lim_q   <= req_limit_i;
      end else if (wait_hit || wait_to) begin
        st_q <= ST_IDLE;
      end
    end
  end

  // R8: an arriving event is always captured
  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((flag_q & $past(evt_i)) == $past(evt_i)));

  // R2: acknowledge drops the request line
  p_ack_drop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && irq_o && !(|evt_i) && !mode_we_i) |=> !irq_o);

  // R11: edge-mode acknowledge holds the line low until return
  p_edge_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && mode_q == IM_EDGE && !irq_ret_i && !mode_we_i) |=> !irq_o);

  // R7: a poll clears its flag when no event collides
  p_poll_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (poll_now && !evt_pad[req_evt_i]) |=> !flag_pad[$past(req_evt_i)]);

  // R9: a finished wait frees the port
  p_wait_exit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && resp_valid_o) |=> !busy_o);
endmodule

// File: rtl/evt_irq_unit.sv
module evt_irq_unit #(
  parameter int CNT_W  = 32,
  parameter int PIN_N  = 64,
  parameter int ADDR_W = 20
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     tmr_period_we_i,
  input  logic [CNT_W-1:0]         tmr_period_i,
  input  logic                     edge_cfg_we_i,
  input  logic [$clog2(PIN_N)+1:0] edge_cfg_i,
  input  logic [PIN_N-1:0]         pins_i,
  input  logic                     bkpt_we_i,
  input  logic [ADDR_W-1:0]        bkpt_addr_i,
  input  logic                     exec_valid_i,
  input  logic [ADDR_W-1:0]        exec_addr_i,
  input  logic                     xfer_roll_i,
  input  logic                     xfer_wrap_i,
  input  logic                     mbox_rd_i,
  input  logic                     mbox_wr_i,
  input  logic                     irq_mode_we_i,
  input  logic [2:0]               irq_mode_i,
  output logic                     irq_o,
  input  logic                     irq_ack_i,
  input  logic                     irq_ret_i,
  input  logic                     req_valid_i,
  input  logic [2:0]               req_evt_i,
  input  logic                     req_take_i,
  input  logic                     req_timed_i,
  input  logic [CNT_W-1:0]         req_limit_i,
  output logic                     resp_valid_o,
  output logic                     resp_flag_o,
  output logic                     resp_timeout_o,
  output logic                     busy_o,
  output logic [CNT_W-1:0]         cnt_o
);
  import evt_pkg::*;

  logic [NUM_EVT-1:0] evt;
  logic tmr_evt, edge_evt, bkpt_evt;

  evt_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i, .rst_ni,
    .period_we_i (tmr_period_we_i),
    .period_i    (tmr_period_i),
    .evt_o       (tmr_evt)
  );

  evt_edge_det #(.PIN_N(PIN_N)) u_edge (
    .clk_i, .rst_ni,
    .cfg_we_i (edge_cfg_we_i),
    .cfg_i    (edge_cfg_i),
    .pins_i   (pins_i),
    .evt_o    (edge_evt)
  );

  evt_bkpt #(.ADDR_W(ADDR_W)) u_bkpt (
    .clk_i, .rst_ni,
    .addr_we_i    (bkpt_we_i),
    .addr_i       (bkpt_addr_i),
    .exec_valid_i (exec_valid_i),
    .exec_addr_i  (exec_addr_i),
    .evt_o        (bkpt_evt)
  );

  always_comb begin
    evt          = '0;
    evt[EV_TMR]  = tmr_evt;
    evt[EV_EDGE] = edge_evt;
    evt[EV_ROLL] = xfer_roll_i;
    evt[EV_WRAP] = xfer_wrap_i;
    evt[EV_MRD]  = mbox_rd_i;
    evt[EV_MWR]  = mbox_wr_i;
    evt[EV_EXEC] = bkpt_evt;
  end

  evt_capture #(.CNT_W(CNT_W)) u_cap (
    .clk_i, .rst_ni,
    .evt_i          (evt),
    .mode_we_i      (irq_mode_we_i),
    .mode_i         (irq_mode_i),
    .irq_ack_i      (irq_ack_i),
    .irq_ret_i      (irq_ret_i),
    .irq_o          (irq_o),
    .req_valid_i    (req_valid_i),
    .req_evt_i      (req_evt_i),
    .req_take_i     (req_take_i),
    .req_timed_i    (req_timed_i),
    .req_limit_i    (req_limit_i),
    .resp_valid_o   (resp_valid_o),
    .resp_flag_o    (resp_flag_o),
    .resp_timeout_o (resp_timeout_o),
    .busy_o         (busy_o),
    .cnt_o          (cnt_o)
  );
endmodule

// File: tb/evt_irq_unit_tb.sv
`timescale 1ns/1ps
module evt_irq_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tmr_we = 0;      logic [31:0] tmr_p = '0;
  logic        ecfg_we = 0;     logic [7:0]  ecfg = '0;
  logic [63:0] pins = '0;
  logic        bk_we = 0;       logic [19:0] bk_addr = '0;
  logic        ex_v = 0;        logic [19:0] ex_addr = '0;
  logic        roll = 0, wrap = 0, mrd = 0, mwr = 0;
  logic        mode_we = 0;     logic [2:0]  mode = '0;
  logic        irq, ack = 0, ret = 0;
  logic        rq_v = 0;        logic [2:0]  rq_e = '0;
  logic        rq_take = 0, rq_timed = 0;
  logic [31:0] rq_lim = '0;
  logic        rs_v, rs_f, rs_to, busy;
  logic [31:0] cnt;

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;  // 125 MHz

  evt_irq_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .tmr_period_we_i(tmr_we), .tmr_period_i(tmr_p),
    .edge_cfg_we_i(ecfg_we), .edge_cfg_i(ecfg), .pins_i(pins),
    .bkpt_we_i(bk_we), .bkpt_addr_i(bk_addr),
    .exec_valid_i(ex_v), .exec_addr_i(ex_addr),
    .xfer_roll_i(roll), .xfer_wrap_i(wrap), .mbox_rd_i(mrd), .mbox_wr_i(mwr),
    .irq_mode_we_i(mode_we), .irq_mode_i(mode), .irq_o(irq),
    .irq_ack_i(ack), .irq_ret_i(ret),
    .req_valid_i(rq_v), .req_evt_i(rq_e), .req_take_i(rq_take),
    .req_timed_i(rq_timed), .req_limit_i(rq_lim),
    .resp_valid_o(rs_v), .resp_flag_o(rs_f), .resp_timeout_o(rs_to),
    .busy_o(busy), .cnt_o(cnt)
  );

  // vector: [7:5] mode, [4:1] strobes {wr,rd,wrap,roll}, [0] expected irq
  localparam logic [7:0] VEC [8] = '{
    {3'd3, 4'b0001, 1'b1}, {3'd3, 4'b0010, 1'b0},
    {3'd4, 4'b0010, 1'b1}, {3'd5, 4'b0100, 1'b1},
    {3'd6, 4'b1000, 1'b1}, {3'd6, 4'b0100, 1'b0},
    {3'd0, 4'b1111, 1'b0}, {3'd5, 4'b1000, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic poll(input logic [2:0] idx, input logic exp, input string tag);
    rq_v = 1; rq_take = 1; rq_timed = 0; rq_e = idx;
    #1;
    chk({tag, " poll valid"}, 32'(rs_v), 32'd1);
    chk(tag, 32'(rs_f), 32'(exp));
    @(negedge clk);
    rq_v = 0; rq_take = 0;
  endtask

  task automatic set_mode(input logic [2:0] m);
    mode_we = 1; mode = m; step(); mode_we = 0;
  endtask

  task automatic set_edge(input logic [7:0] c);
    ecfg_we = 1; ecfg = c; step(); ecfg_we = 0;
  endtask

  task automatic clear_all();
    for (int i = 0; i < 7; i++) begin
      rq_v = 1; rq_take = 1; rq_timed = 0; rq_e = 3'(i);
      step();
    end
    rq_v = 0; rq_take = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: all requirements actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] c0, c_end;
    logic got_v, got_f, got_to;
    int bad;
    step(2);
    rst_n = 1;
    step();
    // reset state
    chk("reset irq R1", 32'(irq), 0);
    chk("reset busy R10", 32'(busy), 0);
    chk("reset resp R7", 32'(rs_v), 0);
    for (int i = 0; i < 8; i++) poll(3'(i), 1'b0, "reset flags R12");

    // table: strobe routing and mode codes
    foreach (VEC[k]) begin
      mode_we = 1; mode = VEC[k][7:5];
      {mwr, mrd, wrap, roll} = VEC[k][4:1];
      step();
      mode_we = 0; {mwr, mrd, wrap, roll} = 4'b0;
      chk($sformatf("vec %0d irq R1 R12", k), 32'(irq), 32'(VEC[k][0]));
      clear_all();
      chk($sformatf("vec %0d cleared R7", k), 32'(irq), 0);
    end
    set_mode(3'd0);

    // R12: one strobe sets only its own flag
    wrap = 1; step(); wrap = 0;
    poll(3'd2, 0, "wrap not roll R12");
    poll(3'd4, 0, "wrap not mrd R12");
    poll(3'd3, 1, "wrap own flag R12");
    poll(3'd7, 0, "index 7 zero R12");

    // R3 timer, period 4; polls at N1..N10
    tmr_we = 1; tmr_p = 32'd4; step(); tmr_we = 0;
    for (int i = 1; i <= 10; i++)
      poll(3'd0, (i == 5 || i == 9), $sformatf("timer poll %0d R3 R8", i));
    tmr_we = 1; tmr_p = 32'd0; step(); tmr_we = 0;
    for (int i = 0; i < 8; i++) poll(3'd0, 0, "timer off R3");

    // R4 edge kinds on pin 5
    set_edge(8'b01_000101);
    step(2);
    poll(3'd1, 0, "edge idle R4");
    pins[5] = 1; step(2);
    poll(3'd1, 1, "rising seen R4");
    pins[5] = 0; step(2);
    poll(3'd1, 0, "falling ignored in rise R4");
    set_edge(8'b10_000101);
    step(3);
    pins[5] = 1; step(2);
    poll(3'd1, 0, "rising ignored in fall R4");
    pins[5] = 0; step(2);
    poll(3'd1, 1, "falling seen R4");

    // R5: move to a pin at a different level
    pins[5] = 1; pins[9] = 0; step(3);
    poll(3'd1, 0, "pre-switch R5");
    set_edge(8'b11_000101);
    step(3);
    poll(3'd1, 0, "settled on pin5 R5");
    set_edge(8'b11_001001);
    step(4);
    poll(3'd1, 0, "no false edge R5");
    pins[9] = 1; step(2);
    poll(3'd1, 1, "either rising R4");

    // R11 / R1 / R2 edge interrupt hold-off
    set_mode(3'd2);
    chk("edge mode idle R1", 32'(irq), 0);
    pins[9] = 0; step(2);
    chk("edge irq R1", 32'(irq), 1);
    ack = 1; step(); ack = 0;
    chk("ack drops R2", 32'(irq), 0);
    pins[9] = 1; step(2);
    chk("held during handler R11", 32'(irq), 0);
    ret = 1; step(); ret = 0;
    chk("released after return R11", 32'(irq), 1);
    ack = 1; step(); ack = 0;
    ret = 1; step(); ret = 0;
    chk("no pending after return R11", 32'(irq), 0);
    set_mode(3'd0);

    // R8 with acknowledge
    set_mode(3'd3);
    roll = 1; step(); roll = 0;
    chk("roll irq R1", 32'(irq), 1);
    ack = 1; roll = 1; step(); ack = 0; roll = 0;
    chk("event beats ack R8", 32'(irq), 1);
    ack = 1; step(); ack = 0;
    chk("ack clears R2", 32'(irq), 0);
    set_mode(3'd0);

    // R6 breakpoint
    ex_v = 1; ex_addr = 20'h0; step(); ex_v = 0;
    poll(3'd6, 0, "unarmed R6");
    bk_we = 1; bk_addr = 20'h007FC; step(); bk_we = 0;
    ex_v = 1; ex_addr = 20'h007FC; step(); ex_v = 0;
    poll(3'd6, 1, "local match R6");
    ex_v = 1; ex_addr = 20'h007F8; step(); ex_v = 0;
    poll(3'd6, 0, "local miss R6");
    bk_we = 1; bk_addr = 20'h12340; step(); bk_we = 0;
    ex_v = 1; ex_addr = 20'h12340; step(); ex_v = 0;
    poll(3'd6, 1, "shared match R6");
    ex_addr = 20'h12340; step();
    poll(3'd6, 0, "no match without valid R6");

    // R9 timed wait that expires
    c0 = cnt;
    rq_v = 1; rq_take = 0; rq_timed = 1; rq_e = 3'd3; rq_lim = c0 + 32'd12;
    step(); rq_v = 0; rq_timed = 0;
    got_v = 0; got_f = 0; got_to = 0; c_end = '0;
    for (int i = 0; i < 40; i++) begin
      if (rs_v) begin got_v = 1; got_f = rs_f; got_to = rs_to; c_end = cnt; break; end
      step();
    end
    chk("timeout resp R9", 32'(got_v), 1);
    chk("timeout flag R9", 32'(got_to), 1);
    chk("timeout no event R9", 32'(got_f), 0);
    chk("timeout cycle R9", c_end, c0 + 32'd12);
    step();
    chk("timeout frees port R9", 32'(busy), 0);

    // R9 timed wait where the event comes first
    c0 = cnt;
    rq_v = 1; rq_timed = 1; rq_e = 3'd3; rq_lim = c0 + 32'd50;
    step(); rq_v = 0; rq_timed = 0;
    step(4);
    wrap = 1; step(); wrap = 0;
    chk("event first resp R9", 32'(rs_v), 1);
    chk("event first flag R9", 32'(rs_f), 1);
    chk("event first no timeout R9", 32'(rs_to), 0);
    step();

    // R10 untimed wait
    rq_v = 1; rq_e = 3'd4; step(); rq_v = 0;
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      if (rs_v || !busy) bad++;
      step();
    end
    chk("indefinite hold R10", 32'(bad), 0);
    mrd = 1; step(); mrd = 0;
    chk("wait done R10", 32'(rs_v), 1);
    chk("wait flag R10", 32'(rs_f), 1);
    step();
    chk("wait idle R10", 32'(busy), 0);
    poll(3'd4, 0, "wait consumed flag R10");

    // R7 poll returns then clears
    mwr = 1; step(); mwr = 0;
    poll(3'd5, 1, "poll returns R7");
    poll(3'd5, 0, "poll cleared R7");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule